// File: doc/BRIEF.md
# Per-Thread Instruction Line Buffer with Shared Retry Slot

This block sits between a multithreaded fetch stage and an instruction memory port. Every thread owns one line buffer holding a whole cache line, the line's base address and a valid bit. A fetch request names a thread and a byte address. If that thread's buffer already holds the line, the line is returned on the same cycle. If it does not, the block sends a read for the line-aligned address to the memory port.

The memory port may refuse a request. A refused request is kept in one retry slot that all threads share. While that slot is occupied, or until the port signals a retry, the block is blocked and no thread may start a new line read. Each thread also has a small request tag that advances on every new read. A response is accepted only if its thread is waiting for a response and the response carries that thread's current tag. A squash of a thread abandons its outstanding read or its parked request, so late data for the squashed read is discarded.

Top module: `ifetch_linebuf`

## Requirements
- R1: The address of every memory request is the fetch address with the low log2(LINE_BYTES) bits forced to zero.
- R2: When fetch_vld is high and the named thread's buffer is valid with a stored base equal to the aligned fetch address, fetch_hit is high, fetch_stall is low, fetch_data is the stored line and no memory request starts. In every other case where fetch_vld is high, fetch_stall is high.
- R3: A fetch that misses, for a thread that is neither waiting for a response nor holding a parked request, with the block not blocked and the thread not squashed, drives mem_req_vld for one cycle with that thread's ID and a tag one above the thread's previous tag (modulo 2^TAG_W, starting at 0 after reset). It stores the new base and clears the buffer's valid bit. If mem_req_rdy is high, the thread then waits for a response.
- R4: If mem_req_rdy is low when a new request is driven, the request goes to the retry slot with its thread, address and tag, and cache_blocked is high from the next cycle.
- R5: While cache_blocked is high, no new line request is issued for any thread. The only request permitted is a resend of the parked request on a mem_retry cycle.
- R6: On a mem_retry cycle with a parked request whose owner is not being squashed, the parked address, thread and tag are driven again. If mem_req_rdy is high, the slot empties, cache_blocked falls and the owner waits for a response.
- R7: A mem_retry cycle with no live parked request clears cache_blocked.
- R8: Squashing the owner of the retry slot empties the slot. cache_blocked remains set until the next mem_retry, and that mem_retry sends nothing.
- R9: A response is accepted only when its thread is waiting for a response, rsp_tag equals that thread's current tag, and the thread is not squashed in the same cycle. Every other rsp_vld cycle pulses rsp_drop in that cycle.
- R10: An accepted response writes the whole line to the thread's buffer and sets it valid. A fetch of that line hits from the next cycle.
- R11: A squash while a thread waits for a response cancels that wait, so a later response carrying the old tag is dropped.
- R12: After reset every buffer is invalid, no request is parked, cache_blocked is low and all tags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Fetch lookup valid |
| fetch_tid | input | TIDW | Thread of the lookup |
| fetch_pc | input | AW | Byte address of the lookup |
| squash | input | NTHR | Per-thread squash, one bit per thread |
| fetch_hit | output | 1 | Lookup hit in the thread's buffer |
| fetch_stall | output | 1 | Lookup valid but not a hit |
| fetch_data | output | LINEW | Line held by the looked-up thread |
| mem_req_vld | output | 1 | Line read request |
| mem_req_rdy | input | 1 | Memory port accepts the request this cycle |
| mem_req_addr | output | AW | Line-aligned read address |
| mem_req_tid | output | TIDW | Thread of the request |
| mem_req_tag | output | TAG_W | Tag of the request |
| mem_retry | input | 1 | Memory port invites a resend |
| rsp_vld | input | 1 | Response valid |
| rsp_tid | input | TIDW | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_data | input | LINEW | Full line of data |
| rsp_drop | output | 1 | Response discarded as stale |
| cache_blocked | output | 1 | New line requests held off |

## Verification
The assertions place no ordering constraints on the memory side. They allow mem_req_rdy and mem_retry to take any value on any cycle, and they allow responses for any thread with any tag at any time. Their only assumption is that fetch_tid and rsp_tid name existing threads, which holds because NTHR is a power of two. The random stimulus uses the full range of both thread fields. It makes a response's tag mostly the thread's current tag, with occasional random tags, so that stale and accepted responses both occur. It also mixes in squashes, refusals and retries at rates that often leave the slot occupied while other threads try to fetch.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
   typedef enum logic [1:0] {
      TH_RUN        = 2'd0,
      TH_WAIT_RSP   = 2'd1,
      TH_WAIT_RETRY = 2'd2
   } th_state_e;
endpackage

// File: rtl/ilb_thread_ctl.sv
module ilb_thread_ctl
   import ilb_pkg::*;
#(
   parameter int TAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             squash_i,
   input  logic             issue_i,
   input  logic             issue_acc_i,
   input  logic             resend_acc_i,
   input  logic             take_i,
   output th_state_e        state_o,
   output logic [TAG_W-1:0] tag_o
);
   th_state_e        st_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TH_RUN;
         tag_q <= '0;
      end else begin
         if (squash_i)
            st_q <= TH_RUN;
         else if (issue_i)
            st_q <= issue_acc_i ? TH_WAIT_RSP : TH_WAIT_RETRY;
         else if (resend_acc_i)
            st_q <= TH_WAIT_RSP;
         else if (take_i)
            st_q <= TH_RUN;
         if (issue_i)
            tag_q <= tag_q + 1'b1;
      end
   end

   assign state_o = st_q;
   assign tag_o   = tag_q;

   // R11
   squash_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i |=> state_o == TH_RUN);
   // R3
   issue_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && issue_acc_i |=> state_o == TH_WAIT_RSP);
endmodule

// File: rtl/ilb_line_store.sv
module ilb_line_store #(
   parameter int AW    = 32,
   parameter int LINEW = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [AW-1:0]    base_i,
   input  logic             fill_i,
   input  logic [LINEW-1:0] data_i,
   output logic             valid_o,
   output logic [AW-1:0]    base_o,
   output logic [LINEW-1:0] data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         base_o  <= '0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b0;
         base_o  <= base_i;
      end else if (fill_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end
   end

   // R10
   fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_i && !load_i |=> valid_o);
   // R3
   load_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !valid_o && base_o == $past(base_i));
endmodule

// File: rtl/ilb_retry_slot.sv
module ilb_retry_slot #(
   parameter int NTHR  = 2,
   parameter int AW    = 32,
   parameter int TAG_W = 3,
   localparam int TIDW = $clog2(NTHR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             park_i,
   input  logic [TIDW-1:0]  park_tid_i,
   input  logic [AW-1:0]    park_addr_i,
   input  logic [TAG_W-1:0] park_tag_i,
   input  logic             retry_i,
   input  logic             req_rdy_i,
   input  logic [NTHR-1:0]  squash_i,
   output logic             live_o,
   output logic [TIDW-1:0]  tid_o,
   output logic [AW-1:0]    addr_o,
   output logic [TAG_W-1:0] tag_o,
   output logic             blocked_o
);
   logic vld_q;

   assign live_o = vld_q && !squash_i[tid_o];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         blocked_o <= 1'b0;
         tid_o     <= '0;
         addr_o    <= '0;
         tag_o     <= '0;
      end else if (park_i) begin
         vld_q     <= 1'b1;
         blocked_o <= 1'b1;
         tid_o     <= park_tid_i;
         addr_o    <= park_addr_i;
         tag_o     <= park_tag_i;
      end else if (retry_i && (!live_o || req_rdy_i)) begin
         vld_q     <= 1'b0;
         blocked_o <= 1'b0;
      end else if (vld_q && squash_i[tid_o]) begin
         vld_q <= 1'b0;
      end
   end

   // R4
   park_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      park_i |=> blocked_o && live_o == !squash_i[tid_o]);
   // R7
   empty_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_i && !live_o && !park_i |=> !blocked_o);
   // R6
   resend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_i && live_o && req_rdy_i |=> !blocked_o && !live_o);
endmodule

// File: rtl/ifetch_linebuf.sv
module ifetch_linebuf
   import ilb_pkg::*;
#(
   parameter int NTHR       = 2,
   parameter int AW         = 32,
   parameter int LINE_BYTES = 16,
   parameter int TAG_W      = 3,
   localparam int TIDW  = $clog2(NTHR),
   localparam int OFFW  = $clog2(LINE_BYTES),
   localparam int LINEW = LINE_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_vld,
   input  logic [TIDW-1:0]  fetch_tid,
   input  logic [AW-1:0]    fetch_pc,
   input  logic [NTHR-1:0]  squash,
   output logic             fetch_hit,
   output logic             fetch_stall,
   output logic [LINEW-1:0] fetch_data,
   output logic             mem_req_vld,
   input  logic             mem_req_rdy,
   output logic [AW-1:0]    mem_req_addr,
   output logic [TIDW-1:0]  mem_req_tid,
   output logic [TAG_W-1:0] mem_req_tag,
   input  logic             mem_retry,
   input  logic             rsp_vld,
   input  logic [TIDW-1:0]  rsp_tid,
   input  logic [TAG_W-1:0] rsp_tag,
   input  logic [LINEW-1:0] rsp_data,
   output logic             rsp_drop,
   output logic             cache_blocked
);
   initial begin
      assert (NTHR >= 2 && (NTHR & (NTHR - 1)) == 0)
         else $error("NTHR must be a power of two of at least 2");
      assert (LINE_BYTES >= 4 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two of at least 4");
      assert (TAG_W >= 1 && AW > OFFW)
         else $error("bad TAG_W or AW");
   end

   th_state_e        st  [NTHR];
   logic [TAG_W-1:0] tg  [NTHR];
   logic             lv  [NTHR];
   logic [AW-1:0]    lb  [NTHR];
   logic [LINEW-1:0] ld  [NTHR];

   logic             sl_live;
   logic [TIDW-1:0]  sl_tid;
   logic [AW-1:0]    sl_addr;
   logic [TAG_W-1:0] sl_tag;

   logic [AW-1:0]    aligned;
   logic             new_issue, resend, take;
   logic [TAG_W-1:0] new_tag;

   assign aligned   = {fetch_pc[AW-1:OFFW], {OFFW{1'b0}}};
   assign fetch_hit = fetch_vld && lv[fetch_tid] && (lb[fetch_tid] == aligned);
   assign fetch_stall = fetch_vld && !fetch_hit;
   assign fetch_data  = ld[fetch_tid];

   assign new_issue = fetch_vld && !fetch_hit && (st[fetch_tid] == TH_RUN)
                      && !cache_blocked && !squash[fetch_tid];
   assign new_tag   = tg[fetch_tid] + 1'b1;
   assign resend    = mem_retry && sl_live;

   assign mem_req_vld  = new_issue || resend;
   assign mem_req_addr = resend ? sl_addr : aligned;
   assign mem_req_tid  = resend ? sl_tid  : fetch_tid;
   assign mem_req_tag  = resend ? sl_tag  : new_tag;

   assign take = rsp_vld && (st[rsp_tid] == TH_WAIT_RSP)
                 && (rsp_tag == tg[rsp_tid]) && !squash[rsp_tid];
   assign rsp_drop = rsp_vld && !take;

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic issue_t, resend_acc_t, take_t;
      assign issue_t      = new_issue && (fetch_tid == TIDW'(t));
      assign resend_acc_t = resend && mem_req_rdy && (sl_tid == TIDW'(t));
      assign take_t       = take && (rsp_tid == TIDW'(t));

      ilb_thread_ctl #(.TAG_W(TAG_W)) u_ctl (
         .clk          (clk),
         .rst_n        (rst_n),
         .squash_i     (squash[t]),
         .issue_i      (issue_t),
         .issue_acc_i  (mem_req_rdy),
         .resend_acc_i (resend_acc_t),
         .take_i       (take_t),
         .state_o      (st[t]),
         .tag_o        (tg[t])
      );

      ilb_line_store #(.AW(AW), .LINEW(LINEW)) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (issue_t),
         .base_i  (aligned),
         .fill_i  (take_t),
         .data_i  (rsp_data),
         .valid_o (lv[t]),
         .base_o  (lb[t]),
         .data_o  (ld[t])
      );

      // R5
      wait_retry_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
         st[t] == TH_WAIT_RETRY |-> cache_blocked);
   end

   ilb_retry_slot #(.NTHR(NTHR), .AW(AW), .TAG_W(TAG_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .park_i      (new_issue && !mem_req_rdy),
      .park_tid_i  (fetch_tid),
      .park_addr_i (aligned),
      .park_tag_i  (new_tag),
      .retry_i     (mem_retry),
      .req_rdy_i   (mem_req_rdy),
      .squash_i    (squash),
      .live_o      (sl_live),
      .tid_o       (sl_tid),
      .addr_o      (sl_addr),
      .tag_o       (sl_tag),
      .blocked_o   (cache_blocked)
   );

   // R1
   req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_vld |-> mem_req_addr[OFFW-1:0] == '0);
   // R5
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_blocked && !mem_retry |-> !mem_req_vld);
   // R9
   squashed_rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld && squash[rsp_tid] |-> rsp_drop);
   // R2
   hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit && !cache_blocked |-> !mem_req_vld);
endmodule

// File: tb/ifetch_linebuf_bench.sv
module ifetch_linebuf_bench;
   localparam int NTHR = 2;
   localparam int AW = 32;
   localparam int TAG_W = 3;
   localparam int LINEW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             f_vld = 0;
   logic [0:0]       f_tid = 0;
   logic [AW-1:0]    f_pc = 0;
   logic [NTHR-1:0]  f_sq = 0;
   logic             m_rdy = 0;
   logic             m_rt = 0;
   logic             r_vld = 0;
   logic [0:0]       r_tid = 0;
   logic [TAG_W-1:0] r_tag = 0;
   logic [LINEW-1:0] r_data = 0;

   logic             o_hit, o_stall, o_req, o_drop, o_blk;
   logic [LINEW-1:0] o_data;
   logic [AW-1:0]    o_addr;
   logic [0:0]       o_tid;
   logic [TAG_W-1:0] o_tag;

   ifetch_linebuf u_ifetch_linebuf (
      .clk(clk), .rst_n(rst_n), .fetch_vld(f_vld), .fetch_tid(f_tid),
      .fetch_pc(f_pc), .squash(f_sq), .fetch_hit(o_hit), .fetch_stall(o_stall),
      .fetch_data(o_data), .mem_req_vld(o_req), .mem_req_rdy(m_rdy),
      .mem_req_addr(o_addr), .mem_req_tid(o_tid), .mem_req_tag(o_tag),
      .mem_retry(m_rt), .rsp_vld(r_vld), .rsp_tid(r_tid), .rsp_tag(r_tag),
      .rsp_data(r_data), .rsp_drop(o_drop), .cache_blocked(o_blk));

   int total = 0;
   int bad = 0;
   bit done = 0;

   // model state: 0 run, 1 waiting response, 2 waiting retry
   int               mst   [NTHR];
   logic [TAG_W-1:0] mtag  [NTHR];
   logic             mval  [NTHR];
   logic [AW-1:0]    mbase [NTHR];
   logic [LINEW-1:0] mdat  [NTHR];
   logic             sv, mblk;
   logic [0:0]       st_t;
   logic [AW-1:0]    sa;
   logic [TAG_W-1:0] stg;

   task automatic chk(input bit ok, input string rq, input logic [LINEW-1:0] act,
                      input logic [LINEW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
      return {a[AW-1:4], 4'b0};
   endfunction

   task automatic model_reset();
      for (int t = 0; t < NTHR; t++) begin
         mst[t] = 0; mtag[t] = 0; mval[t] = 0; mbase[t] = 0; mdat[t] = 0;
      end
      sv = 0; mblk = 0; st_t = 0; sa = 0; stg = 0;
   endtask

   // inputs already driven after a falling edge; check and advance model
   task automatic step();
      logic [AW-1:0] al;
      logic ehit, eiss, slive, eres, etake, evld;
      logic [AW-1:0] eaddr;
      logic [0:0] etid;
      logic [TAG_W-1:0] etag;
      #5;
      al    = align(f_pc);
      ehit  = f_vld && mval[f_tid] && mbase[f_tid] == al;
      eiss  = f_vld && !ehit && mst[f_tid] == 0 && !mblk && !f_sq[f_tid];
      slive = sv && !f_sq[st_t];
      eres  = m_rt && slive;
      evld  = eiss || eres;
      eaddr = eres ? sa : al;
      etid  = eres ? st_t : f_tid;
      etag  = eres ? stg : mtag[f_tid] + 1'b1;
      etake = r_vld && mst[r_tid] == 1 && r_tag == mtag[r_tid] && !f_sq[r_tid];
      chk(o_req == evld, "R5 request valid", o_req, evld);
      if (evld) begin
         chk(o_addr == eaddr, "R1 request address", o_addr, eaddr);
         chk(o_tid == etid && o_tag == etag, "R6 request tid/tag",
             {o_tid, o_tag}, {etid, etag});
      end
      chk(o_hit == ehit, "R2 hit", o_hit, ehit);
      chk(o_stall == (f_vld && !ehit), "R2 stall", o_stall, f_vld && !ehit);
      if (ehit) chk(o_data == mdat[f_tid], "R10 line data", o_data, mdat[f_tid]);
      chk(o_drop == (r_vld && !etake), "R9 drop", o_drop, r_vld && !etake);
      chk(o_blk == mblk, "R4 blocked", o_blk, mblk);
      // advance model
      for (int t = 0; t < NTHR; t++) begin
         if (f_sq[t]) mst[t] = 0;
         else if (eiss && f_tid == t) mst[t] = m_rdy ? 1 : 2;
         else if (eres && m_rdy && st_t == t) mst[t] = 1;
         else if (etake && r_tid == t) mst[t] = 0;
         if (eiss && f_tid == t) begin
            mtag[t] = mtag[t] + 1'b1; mval[t] = 0; mbase[t] = al;
         end else if (etake && r_tid == t) begin
            mval[t] = 1; mdat[t] = r_data;
         end
      end
      if (eiss && !m_rdy) begin
         sv = 1; mblk = 1; st_t = f_tid; sa = al; stg = etag;
      end else if (m_rt && (!slive || m_rdy)) begin
         sv = 0; mblk = 0;
      end else if (sv && f_sq[st_t]) sv = 0;
      @(negedge clk);
   endtask

   task automatic idle_in();
      f_vld = 0; f_sq = 0; m_rdy = 0; m_rt = 0; r_vld = 0;
   endtask

   initial begin
      int seed;
      seed = $urandom(4242);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12: reset state
      idle_in();
      chk(o_blk == 0 && o_req == 0 && o_hit == 0, "R12 reset outputs",
          {o_blk, o_req, o_hit}, 0);
      step();
      // R4: refused miss parks
      f_vld = 1; f_tid = 0; f_pc = 32'h1237; m_rdy = 0; step();
      // R5: other thread blocked
      idle_in(); f_vld = 1; f_tid = 1; f_pc = 32'h2000; m_rdy = 1; step();
      // R6: retry resends, accepted
      idle_in(); m_rt = 1; m_rdy = 1; step();
      // R10: matching response fills; then hit
      idle_in(); r_vld = 1; r_tid = 0; r_tag = 3'd1; r_data = 128'hA5A5_0001; step();
      idle_in(); f_vld = 1; f_tid = 0; f_pc = 32'h123C; step();
      // R8: park, squash owner, retry sends nothing and unblocks
      idle_in(); f_vld = 1; f_tid = 1; f_pc = 32'h3004; m_rdy = 0; step();
      idle_in(); f_sq = 2'b10; step();
      idle_in(); m_rt = 1; m_rdy = 1; step();
      // R7: retry with empty slot
      idle_in(); m_rt = 1; step();
      // R11: squash during wait, old-tag response dropped
      idle_in(); f_vld = 1; f_tid = 1; f_pc = 32'h4000; m_rdy = 1; step();
      idle_in(); f_sq = 2'b10; step();
      idle_in(); r_vld = 1; r_tid = 1; r_tag = mtag[1]; r_data = 128'h77; step();
      // R3: fresh miss accepted straight away
      idle_in(); f_vld = 1; f_tid = 1; f_pc = 32'h4008; m_rdy = 1; step();
      // random phase
      for (int i = 0; i < 4000; i++) begin
         f_vld  = ($urandom % 4) != 0;
         f_tid  = 1'($urandom);
         f_pc   = 32'h8000 + ($urandom % 4) * 32'h40 + ($urandom % 16);
         f_sq   = {($urandom % 20) == 0, ($urandom % 20) == 0};
         m_rdy  = ($urandom % 10) < 6;
         m_rt   = ($urandom % 5) == 0;
         r_vld  = ($urandom % 3) == 0;
         r_tid  = 1'($urandom);
         r_tag  = (($urandom % 4) == 0) ? 3'($urandom) : mtag[r_tid];
         r_data = {$urandom, $urandom, $urandom, $urandom};
         step();
      end
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule